// File: doc/BRIEF.md
# Prescaled Down-Counting Event Timer

This block is a register-mapped timer. It holds an 8-bit counter that software can load and read back, and a control register. The counter steps down once for each output pulse of a 7-bit prescaler. The prescaler in turn advances on ticks drawn from one of four input sources. The internal instruction-cycle enable can drive the ticks, or that enable gated by the timer pin, or falling edges of the timer pin alone. The fourth source is a halted setting in which nothing counts. The source choice is held as an enumerated mode, `SRC_CYC`, `SRC_GATED`, `SRC_HALT` and `SRC_PIN`, and a `unique case` over that mode picks the tick. The mode changes only through a control write, and any of the four modes can be reached directly from any other.

When the counter steps into zero, a sticky request flag is set. The counter then keeps running and wraps from 0 to 255, so software can measure how far past zero it has counted. The request line is raised while three conditions hold together: the flag is set, the local mask is clear, and the processor's global mask is clear. The timer pin passes through a two-flop synchronizer. Its falling edge is detected in the system clock domain, so the whole block runs on a single clock.

Top module: `pscl_dntimer`

## Requirements
- R1: After reset, the counter reads 0xFF and the control register reads 0x77: flag 0, mask 1, mode 11, clear bit 0, tap 7. The `irq` output is low.
- R2: Writing the counter (`wr_sel`=0) loads `wr_data`, and this takes priority over a count in the same cycle. Reading with `rd_sel`=0 returns the count and does not change it.
- R3: Each prescaler output pulse lowers the counter by one, modulo 256, so the counter wraps from 0 to 0xFF.
- R4: A step that takes the counter from 1 to 0 sets the flag, which is control bit 7.
- R5: The flag stays set until a control write clears it. A control write with bit 7 = 1 sets it. If a step into zero happens in the same cycle as a control write with bit 7 = 0, the flag ends up set.
- R6: `irq` is high exactly when control bit 7 = 1, control bit 6 = 0 and `cpu_imask` = 0.
- R7: Mode 00 (control bits 5:4) takes one tick per cycle with `cyc_en` = 1.
- R8: Mode 01 takes one tick per cycle with `cyc_en` = 1 while the synchronized pin is high, and none while it is low.
- R9: Mode 10 produces no ticks, whatever `cyc_en` and the pin do.
- R10: Mode 11 takes one tick per falling edge of `tmr_pin` and ignores `cyc_en`. The pin passes through two synchronizer flops first.
- R11: Tap n (control bits 2:0) gives one counter step per 2^n ticks, with n from 0 to 7. After a prescaler clear, the first step comes on tick 2^n.
- R12: A control write with bit 3 = 1 clears the prescaler to zero. Bit 3 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | Internal instruction-cycle enable, one tick source |
| tmr_pin | input | 1 | External timer pin, asynchronous |
| cpu_imask | input | 1 | Global processor interrupt mask |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 counter, 1 control |
| rd_data | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a step into zero landing in the same cycle as a software write that clears the flag. The bench loads the counter with 1 and selects the cycle-enable source at divide-by-one. It then asserts `cyc_en` in exactly the cycle that carries the clearing control write, so the crossing and the write coincide. A second hard case is the prescaler at wide taps, where a missing clear shows up only after 128 ticks. The bench handles this by running two 100-tick stretches on either side of a clear and checking that the counter has not moved.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
    typedef enum logic [1:0] {
        SRC_CYC   = 2'b00,
        SRC_GATED = 2'b01,
        SRC_HALT  = 2'b10,
        SRC_PIN   = 2'b11
    } src_mode_e;

    localparam int CTL_FLAG = 7;
    localparam int CTL_MASK = 6;
    localparam int CTL_CLR  = 3;
endpackage

// File: rtl/dtm_src_sel.sv
module dtm_src_sel
    import dtm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  src_mode_e mode,
    input  logic      cyc_en,
    input  logic      pin,
    output logic      tick
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;
    logic               pin_lvl;
    logic               pin_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-2:0], pin};
    end

    assign pin_lvl  = chain[SYNC_STAGES-1];
    assign pin_fall = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

    always_comb begin
        unique case (mode)
            SRC_CYC:   tick = cyc_en;
            SRC_GATED: tick = cyc_en & pin_lvl;
            SRC_HALT:  tick = 1'b0;
            SRC_PIN:   tick = pin_fall;
            default:   tick = 1'b0;
        endcase
    end

    p_pin_ignores_cyc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SRC_PIN && tick) |-> $past(chain[SYNC_STAGES-1]));
endmodule

// File: rtl/dtm_prescale.sv
module dtm_prescale #(
    parameter int PRE_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] tap,
    output logic             step
);
    logic [PRE_W-1:0] pre;
    logic [PRE_W:0]   wide_mask;
    logic [PRE_W-1:0] tap_mask;

    assign wide_mask = ({{PRE_W{1'b0}}, 1'b1} << tap) - 1'b1;
    assign tap_mask  = wide_mask[PRE_W-1:0];
    assign step      = tick && ((pre & tap_mask) == tap_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pre <= '0;
        else if (clr)  pre <= '0;
        else if (tick) pre <= pre + 1'b1;
    end

    p_clear_zeroes_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> pre == '0);
    p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(pre));
endmodule

// File: rtl/dtm_regs.sv
module dtm_regs
    import dtm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic             wr_ctl,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             mask,
    output src_mode_e        mode,
    output logic [SEL_W-1:0] tap,
    output logic             pre_clr
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic zero_hit;

    assign zero_hit = step && !wr_cnt && (cnt == ONE);
    assign pre_clr  = wr_ctl && wr_data[CTL_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '1;
        else if (wr_cnt) cnt <= wr_data;
        else if (step)   cnt <= cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
            mask <= 1'b1;
            mode <= SRC_PIN;
            tap  <= '1;
        end else begin
            if (wr_ctl) begin
                flag <= wr_data[CTL_FLAG] | zero_hit;
                mask <= wr_data[CTL_MASK];
                mode <= src_mode_e'(wr_data[5:4]);
                tap  <= wr_data[SEL_W-1:0];
            end else if (zero_hit) begin
                flag <= 1'b1;
            end
        end
    end

    p_step_decrements_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_cnt) |=> cnt == $past(cnt) - 1'b1);
    p_count_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_cnt) |=> $stable(cnt));
    p_zero_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_cnt && cnt == ONE) |=> flag);
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_ctl) |=> flag);
endmodule

// File: rtl/pscl_dntimer.sv
module pscl_dntimer
    import dtm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             tmr_pin,
    input  logic             cpu_imask,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    localparam int SEL_W = $clog2(PRE_W + 1);

    src_mode_e        mode;
    logic [SEL_W-1:0] tap;
    logic [CNT_W-1:0] cnt;
    logic             flag, mask, pre_clr, tick, step;
    logic             wr_cnt, wr_ctl;
    logic [CNT_W-1:0] ctl_view;

    assign wr_cnt = wr_en && !wr_sel;
    assign wr_ctl = wr_en &&  wr_sel;

    dtm_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .cyc_en(cyc_en), .pin(tmr_pin), .tick(tick)
    );

    dtm_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .clr(pre_clr), .tap(tap), .step(step)
    );

    dtm_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_ctl(wr_ctl),
        .wr_data(wr_data), .step(step), .cnt(cnt), .flag(flag),
        .mask(mask), .mode(mode), .tap(tap), .pre_clr(pre_clr)
    );

    always_comb begin
        ctl_view              = '0;
        ctl_view[CTL_FLAG]    = flag;
        ctl_view[CTL_MASK]    = mask;
        ctl_view[5:4]         = mode;
        ctl_view[SEL_W-1:0]   = tap;
    end

    assign rd_data = rd_sel ? ctl_view : cnt;
    assign irq     = flag && !mask && !cpu_imask;

    p_halt_no_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SRC_HALT) |-> !step);
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !cpu_imask);
    p_clear_bit_hidden_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> !rd_data[CTL_CLR]);
endmodule

// File: tb/pscl_dntimer_bench.sv
module pscl_dntimer_bench;
    logic       clk = 0, rst_n = 0;
    logic       cyc_en = 0, tmr_pin = 0, cpu_imask = 0;
    logic       wr_en = 0, wr_sel = 0, rd_sel = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       irq;
    int         n_cmp = 0, n_bad = 0;

    always #2 clk = ~clk;

    pscl_dntimer u_pscl_dntimer (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .tmr_pin(tmr_pin),
        .cpu_imask(cpu_imask), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_sel = sel; #1; v = rd_data;
    endtask

    task automatic run(input int k);
        @(negedge clk); cyc_en = 1;
        repeat (k) @(posedge clk);
        @(negedge clk); cyc_en = 0;
    endtask

    task automatic pulses(input int k);
        for (int i = 0; i < k; i++) begin
            tmr_pin = 1; repeat (4) @(negedge clk);
            tmr_pin = 0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (all R) actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        int dec;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(0, v); check("R1 reset count", v, 8'hFF);
        rd(1, v); check("R1 reset control", v, 8'h77);
        check("R1 reset irq", irq, 0);

        // R7 R11 R3 R4: sweep every tap in cycle-enable mode
        for (int n = 0; n < 8; n++) begin
            wr(0, 8'd200);
            wr(1, 8'h48 | 8'(n));
            run(300);
            dec = 300 >> n;
            rd(0, v); check($sformatf("R3 R7 R11 count tap %0d", n), v, (200 - dec) & 8'hFF);
            rd(1, v); check($sformatf("R4 flag tap %0d", n), v[7], dec >= 200);
            check($sformatf("R12 clr reads 0 tap %0d", n), v[3], 0);
        end
        // after the tap-0 style crossing, more counting keeps the flag: R5
        wr(0, 8'd2); wr(1, 8'h48); run(10);
        run(5);
        rd(1, v); check("R5 flag sticky after further steps", v[7], 1);
        wr(1, 8'h60);
        rd(1, v); check("R5 flag cleared by write", v, 8'h60);

        // R2: read does not disturb
        wr(0, 8'h5A);
        rd(0, v); repeat (3) @(negedge clk); rd(0, v2);
        check("R2 load value", v, 8'h5A);
        check("R2 read stable", v2, 8'h5A);

        // R9: halted mode ignores cyc_en and pin
        @(negedge clk); cyc_en = 1;
        pulses(5);
        cyc_en = 0;
        rd(0, v); check("R9 halt no count", v, 8'h5A);

        // R8: gated mode
        wr(1, 8'h58); wr(0, 8'd100);
        tmr_pin = 1; repeat (4) @(negedge clk);
        run(30);
        rd(0, v); check("R8 gated pin high", v, 70);
        tmr_pin = 0; repeat (4) @(negedge clk);
        run(30);
        rd(0, v); check("R8 gated pin low", v, 70);

        // R10: pin mode, cyc_en ignored
        wr(1, 8'h78); wr(0, 8'd50);
        @(negedge clk); cyc_en = 1;
        pulses(10);
        cyc_en = 0;
        rd(0, v); check("R10 pin edges tap0", v, 40);
        wr(1, 8'h7A); wr(0, 8'd50);
        pulses(12);
        rd(0, v); check("R10 R11 pin edges tap2", v, 47);

        // R12: prescaler clear at tap 7
        wr(1, 8'h4F); wr(0, 8'd100);
        run(100);
        wr(1, 8'h4F);
        run(100);
        rd(0, v); check("R12 prescaler cleared", v, 100);
        rd(1, v); check("R12 bit3 reads zero", v, 8'h47);

        // R6: interrupt gating
        wr(1, 8'hA0);
        cpu_imask = 0; #1; check("R6 irq flag unmasked", irq, 1);
        cpu_imask = 1; #1; check("R6 irq cpu masked", irq, 0);
        cpu_imask = 0;
        wr(1, 8'hE0); #1; check("R6 irq local masked", irq, 0);

        // R5: zero crossing coincides with clearing write
        wr(1, 8'hC0); wr(0, 8'd1);
        @(negedge clk); wr_en = 1; wr_sel = 1; wr_data = 8'h40; cyc_en = 1;
        @(negedge clk); wr_en = 0; cyc_en = 0;
        rd(1, v); check("R5 crossing beats clear", v, 8'hC0);
        rd(0, v); check("R3 reached zero", v, 0);
        wr(1, 8'h60);
        rd(1, v); check("R5 plain clear", v[7], 0);

        // R2: load beats a step in the same cycle
        wr(1, 8'h48);
        @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 8'h33; cyc_en = 1;
        @(negedge clk); wr_en = 0; cyc_en = 0;
        rd(0, v); check("R2 load priority", v, 8'h33);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule